// File: doc/BRIEF.md
# End-of-Record Check Character Sequencer

This block closes a tape record once its last data character has gone out. While a record is written, each data character arrives on a valid/ready stream and is folded into two running checks. One is a longitudinal parity byte, the XOR of every character. The other is a 9-bit rotate-and-XOR code, used in 9-track mode only. When the write logic has finished the final character of the final word, it pulses `start`. The block then times the blank trailer in character clocks and strobes out the check characters.

In 7-track mode the trailer is a four-character blank space followed by the longitudinal character. In 9-track mode it is a four-character space, the code character, a second four-character space and then the longitudinal character. The longitudinal character in 9-track mode also covers the code character. A single recycling 2-bit space counter times both spaces. One clock after the longitudinal strobe, a `done` pulse tells the controller that the trailer is complete. A synchronous `clr` begins a new operation. It empties both accumulators and abandons any trailer in progress.

Back-pressure on the data stream is simple. `in_ready` is high only while no trailer is running. A character is taken on a clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, an offered character stays with the sender and has no effect. `mode_nine` must be held steady for a whole record.

Top module: `eor_trailer_seq`

## Requirements
- R1: After reset, `wr_crc`, `wr_lpc`, `done` and `chk_char` are 0, `in_ready` is 1, and both accumulators are zero, so a first record needs no `clr`.
- R2: `in_ready` is 1 only while no trailer is running. It falls on the clock edge that takes `start` and rises again on the edge that issues the longitudinal strobe.
- R3: The longitudinal character is the XOR of every accepted character. In 7-track mode (`mode_nine`=0) only bits 5:0 of each character count, and bits 7:6 of the result are 0.
- R4: In 9-track mode (`mode_nine`=1), every accepted character updates a 9-bit code register c to {c[7:0], c[8]} ^ {1'b0, char}. The code character is c[7:0]. The code register does not change in 7-track mode.
- R5: `start` in the idle state begins a space of four `char_tick` pulses. In 7-track mode the fifth `char_tick` after `start` raises `wr_lpc` on that clock edge.
- R6: In 9-track mode the fifth `char_tick` raises `wr_crc`. A second four-tick space follows, and the tenth tick raises `wr_lpc`. The longitudinal character then also includes the code character.
- R7: Each strobe lasts one clock, and the two strobes are never high together. `chk_char` carries the strobed character from the strobe cycle onward and holds it until the next strobe.
- R8: `done` is high for exactly the one clock that follows the `wr_lpc` clock.
- R9: `clr` zeroes both accumulators and returns a running trailer to idle, with no strobe issued.
- R10: While a trailer runs, an offered character is not taken and does not change the longitudinal character, and a repeated `start` does not change the strobe timing. A `char_tick` in the idle state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous new-operation clear |
| mode_nine | input | 1 | 1 = 9-track, 0 = 7-track |
| char_tick | input | 1 | One-clock pulse per character time |
| start | input | 1 | Data finished; begin the trailer |
| in_valid | input | 1 | Data character offered |
| in_ready | output | 1 | Data character can be taken |
| in_char | input | 8 | Data character |
| wr_crc | output | 1 | Strobe: write the code character |
| wr_lpc | output | 1 | Strobe: write the longitudinal character |
| chk_char | output | 8 | Check character being written |
| done | output | 1 | Trailer finished |

## Verification
A character offered with `in_ready` high is counted on the next rising edge. Its effect is only visible later, in the strobed check character. The trailer strobes are registered, so `wr_crc` or `wr_lpc` appears right after the edge that sees the fifth or tenth `char_tick`. `done` appears one edge after `wr_lpc`. The bench drives each input on the falling edge and reads the outputs one falling edge after the tick. It counts ticks to find which one produced each strobe. It checks `done` in the single spare cycle after the longitudinal strobe, with the tick held low.

// File: rtl/eor_pkg.sv
package eor_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP1,
    ST_CRC,
    ST_GAP2,
    ST_LPC
  } trl_state_e;
endpackage

// File: rtl/eor_accum.sv
module eor_accum #(
  parameter int CHAR_W  = 8,
  parameter int SHORT_W = 6,
  parameter int CRC_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              nine,
  input  logic [CHAR_W-1:0] ch,
  input  logic              fold,
  output logic [CHAR_W-1:0] lpc,
  output logic [CHAR_W-1:0] crc_chr
);
  localparam logic [CHAR_W-1:0] SHORT_MASK =
    {{(CHAR_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic [CRC_W-1:0]  crc;
  logic [CHAR_W-1:0] ch_eff;
  logic [CRC_W-1:0]  crc_nxt;

  assign ch_eff  = nine ? ch : (ch & SHORT_MASK);
  assign crc_nxt = {crc[CRC_W-2:0], crc[CRC_W-1]} ^ CRC_W'(ch);
  assign crc_chr = crc[CHAR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpc <= '0;
      crc <= '0;
    end else if (clr) begin
      lpc <= '0;
      crc <= '0;
    end else begin
      if (take) begin
        lpc <= lpc ^ ch_eff;
        if (nine) crc <= crc_nxt;
      end else if (fold) begin
        lpc <= lpc ^ crc[CHAR_W-1:0];
      end
    end
  end

  // R10: the parity holds unless a character is taken or the code is folded in
  a_r10_lpc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !fold && !clr) |=> $stable(lpc));

  // R4: the code register stays put in 7-track mode
  a_r4_crc_short_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!nine && !clr) |=> $stable(crc));
endmodule

// File: rtl/eor_gap_seq.sv
module eor_gap_seq
  import eor_pkg::*;
#(
  parameter int GAP_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic start,
  input  logic nine,
  output logic idle,
  output logic crc_fire,
  output logic lpc_fire
);
  localparam int CW = (GAP_LEN > 1) ? $clog2(GAP_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP_LEN - 1);

  trl_state_e st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (clr) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st  <= ST_GAP1;
          cnt <= '0;
        end
        ST_GAP1, ST_GAP2: if (tick) begin
          if (cnt == LAST) begin
            cnt <= '0;
            if (st == ST_GAP1) st <= nine ? ST_CRC : ST_LPC;
            else               st <= ST_LPC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CRC: if (tick) st <= ST_GAP2;
        ST_LPC: if (tick) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle     = (st == ST_IDLE);
  assign crc_fire = (st == ST_CRC) && tick && !clr;
  assign lpc_fire = (st == ST_LPC) && tick && !clr;

  // R5: the space counter rests at zero outside the spaces
  a_r5_cnt_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (cnt == '0));

  // R6: the second space is entered only from the code-character step
  a_r6_gap2_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_GAP2) && ($past(st) != ST_GAP2)) |-> ($past(st) == ST_CRC));
endmodule

// File: rtl/eor_trailer_seq.sv
module eor_trailer_seq #(
  parameter int CHAR_W  = 8,
  parameter int SHORT_W = 6,
  parameter int CRC_W   = 9,
  parameter int GAP_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mode_nine,
  input  logic              char_tick,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_char,
  output logic              wr_crc,
  output logic              wr_lpc,
  output logic [CHAR_W-1:0] chk_char,
  output logic              done
);
  logic idle, crc_fire, lpc_fire, take;
  logic [CHAR_W-1:0] lpc, crc_chr;

  assign in_ready = idle;
  assign take     = in_valid && idle && !clr;

  eor_gap_seq #(.GAP_LEN(GAP_LEN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .tick     (char_tick),
    .start    (start),
    .nine     (mode_nine),
    .idle     (idle),
    .crc_fire (crc_fire),
    .lpc_fire (lpc_fire)
  );

  eor_accum #(.CHAR_W(CHAR_W), .SHORT_W(SHORT_W), .CRC_W(CRC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .take    (take),
    .nine    (mode_nine),
    .ch      (in_char),
    .fold    (crc_fire),
    .lpc     (lpc),
    .crc_chr (crc_chr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_crc   <= 1'b0;
      wr_lpc   <= 1'b0;
      done     <= 1'b0;
      chk_char <= '0;
    end else begin
      wr_crc <= crc_fire;
      wr_lpc <= lpc_fire;
      done   <= wr_lpc;
      if (crc_fire)      chk_char <= crc_chr;
      else if (lpc_fire) chk_char <= lpc;
    end
  end

  // R7: the two strobes never coincide
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_crc && wr_lpc));

  // R7: the code strobe lasts one clock
  a_r7_crc_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_crc |=> !wr_crc);

  // R8: done follows the longitudinal strobe
  a_r8_done_after: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lpc |=> done);

  // R8: done has no other cause
  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_lpc));
endmodule

// File: tb/test_eor_trailer_seq.sv
module test_eor_trailer_seq;
  logic clk = 1'b0;
  logic rst_n, clr, mode_nine, char_tick, start, in_valid;
  logic in_ready, wr_crc, wr_lpc, done;
  logic [7:0] in_char, chk_char;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  eor_trailer_seq i_eor_trailer_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode_nine(mode_nine),
    .char_tick(char_tick), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_char(in_char), .wr_crc(wr_crc),
    .wr_lpc(wr_lpc), .chk_char(chk_char), .done(done)
  );

  // {nine, count[2:0], chars[31:0], crc tick[3:0], lpc tick[3:0]}
  localparam logic [43:0] VEC [6] = '{
    44'h3_12345678_05,
    44'hC_A53CFF01_5A,
    44'h4_FFC03F81_05,
    44'h9_80000000_5A,
    44'h8_00000000_5A,
    44'h1_C3000000_05
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_record(input bit nine, input int n, input logic [31:0] chars,
                            input bit do_clr, input int exp_crc_t, input int exp_lpc_t,
                            input bit junk);
    logic [8:0] m_crc;
    logic [7:0] m_lpc, c;
    int crc_t, lpc_t;
    m_crc = '0; m_lpc = '0; crc_t = 0; lpc_t = 0;
    mode_nine = nine;
    if (do_clr) begin
      clr = 1'b1; @(negedge clk); clr = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      c = chars[31-8*i -: 8];
      in_valid = 1'b1; in_char = c;
      check(in_ready == 1'b1, "R2 ready while idle", in_ready, 1);
      @(negedge clk);
      in_valid = 1'b0;
      if (nine) begin
        m_lpc = m_lpc ^ c;
        m_crc = {m_crc[7:0], m_crc[8]} ^ {1'b0, c};
      end else begin
        m_lpc = m_lpc ^ (c & 8'h3F);
      end
    end
    if (nine) m_lpc = m_lpc ^ m_crc[7:0];
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(in_ready == 1'b0, "R2 not ready in trailer", in_ready, 0);
    for (int t = 1; t <= 12 && lpc_t == 0; t++) begin
      if (junk) begin
        in_valid = 1'b1; in_char = 8'hFF;
        if (t == 2) start = 1'b1;
      end
      char_tick = 1'b1; @(negedge clk);
      char_tick = 1'b0; in_valid = 1'b0; start = 1'b0;
      if (wr_crc) begin
        crc_t = t;
        check(chk_char == m_crc[7:0], "R4 code character", chk_char, m_crc[7:0]);
      end
      if (wr_lpc) begin
        lpc_t = t;
        check(chk_char == m_lpc, "R3 R6 R10 longitudinal character", chk_char, m_lpc);
      end
      @(negedge clk);
      if (lpc_t != 0) begin
        check(done == 1'b1 && wr_lpc == 1'b0, "R8 done after strobe", {done, wr_lpc}, 2'b10);
        check(chk_char == m_lpc, "R7 character held", chk_char, m_lpc);
      end else begin
        check(wr_crc == 1'b0 && done == 1'b0, "R7 one-clock strobe", {wr_crc, done}, 0);
      end
    end
    check(crc_t == exp_crc_t, "R5 R6 code strobe tick", crc_t, exp_crc_t);
    check(lpc_t == exp_lpc_t, "R5 R6 longitudinal strobe tick", lpc_t, exp_lpc_t);
    @(negedge clk);
    check(done == 1'b0, "R8 done single", done, 0);
    check(in_ready == 1'b1, "R2 ready after trailer", in_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; mode_nine = 1'b0; char_tick = 1'b0;
    start = 1'b0; in_valid = 1'b0; in_char = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({wr_crc, wr_lpc, done} == 3'b000, "R1 strobes low", {wr_crc, wr_lpc, done}, 0);
    check(chk_char == 8'h00, "R1 character zero", chk_char, 0);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    // R10: ticks while idle change nothing
    char_tick = 1'b1; repeat (3) @(negedge clk); char_tick = 1'b0;
    check({wr_crc, wr_lpc, in_ready} == 3'b001, "R10 idle ticks", {wr_crc, wr_lpc, in_ready}, 1);

    // table walk; the first record relies on the reset-cleared accumulators (R1)
    for (int k = 0; k < 6; k++) begin
      logic [43:0] v;
      v = VEC[k];
      run_record(v[43], int'(v[42:40]), v[39:8], k != 0, int'(v[7:4]), int'(v[3:0]), k == 2);
    end

    // R9: clear aborts a trailer and empties the accumulators
    mode_nine = 1'b1;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    in_valid = 1'b1; in_char = 8'h5C; @(negedge clk);
    in_char = 8'hE7; @(negedge clk); in_valid = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    char_tick = 1'b1; repeat (2) @(negedge clk); char_tick = 1'b0;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check(in_ready == 1'b1, "R9 abort to idle", in_ready, 1);
    for (int t = 0; t < 6; t++) begin
      char_tick = 1'b1; @(negedge clk); char_tick = 1'b0;
      check({wr_crc, wr_lpc} == 2'b00, "R9 no strobe after abort", {wr_crc, wr_lpc}, 0);
    end
    run_record(1'b1, 0, 32'h0, 1'b0, 5, 10, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule